// File: doc/BRIEF.md
# Pin Event Interrupt Unit

This block watches a configurable set of general-purpose input pins and turns selected pin activity into interrupts. Every pin is first brought into the local clock domain through a two-stage synchroniser. A per-source trigger detector then compares the synchronised value against the value it had one cycle earlier. Each detected event lands in a sticky status bit, and every pending status bit whose source is enabled is ORed onto a single interrupt line for the whole block.

Software talks to the unit over a byte-wide register port with an address, a write strobe, write data and registered read data. Each source owns one configuration byte, which holds a trigger code and an enable flag. The status bits are packed eight to a byte, and software clears them by writing ones. A typical handler reads the status bytes, services the sources it finds, and writes the same bits back to acknowledge them. For a level trigger, the bit comes straight back for as long as the pin holds its active level.

Top module: `pin_event_irq`

## Requirements
- R1: The configuration byte of source n sits at address CFG_BASE+n (default 0x300). All eight bits are stored and read back as written. Bit 7 is the enable, bits 2:0 are the trigger code, and bits 6:3 have no function.
- R2: A read returns the addressed register on the clock edge after the address is presented. Until that edge, read data keeps its previous value.
- R3: Trigger code 0 (low level) sets the status bit on every cycle that the synchronised pin is 0.
- R4: Trigger code 1 (high level) sets the status bit on every cycle that the synchronised pin is 1.
- R5: Trigger code 2 sets the status bit only on a 1-to-0 transition of the synchronised pin. Trigger code 3 sets it only on a 0-to-1 transition.
- R6: Trigger code 4 sets the status bit on a transition of the synchronised pin in either direction.
- R7: Trigger codes 5, 6 and 7 never set the status bit.
- R8: The status bit of source n is bit n%8 of the byte at address STAT_BASE+n/8 (default 0x360). Bits that belong to no source read as 0.
- R9: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A set bit otherwise stays set.
- R10: When a detection and a clear hit the same status bit in the same cycle, the bit stays set. A status bit can only become set through a detection.
- R11: A status bit is set by its trigger whether or not its source is enabled.
- R12: The interrupt output is high exactly when at least one source has both its status bit and its enable bit set. Enabling a source whose bit is already pending raises the interrupt right after the write.
- R13: While reset is asserted, read data and the interrupt output are 0. After reset, every configuration byte reads 0, which means disabled with the low-level trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pins_i | input | NUM_SRC | Asynchronous pin inputs, one per source |
| bus_addr_i | input | ADDR_W | Register byte address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench walks every source through every trigger code, including the three reserved codes, with a low, rising, high and falling pin sequence. At each step it clears and rereads the status bit. A detector with swapped edge polarity, or a reserved code that decodes to an edge, shows up as a wrong bit in one step of that walk. A level mode where the clear beats the detection would read back 0 while the pin still holds its active level. Writes of mixed ones and zeros to a status byte catch clear logic that drops neighbouring bits. Enabling a source that is already pending catches an interrupt gated on new events rather than on stored status. A status bit packed at the wrong byte or bit position fails the walk for the sources above index 7.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;

  typedef enum logic [2:0] {
    TRG_LOW  = 3'd0,
    TRG_HIGH = 3'd1,
    TRG_FALL = 3'd2,
    TRG_RISE = 3'd3,
    TRG_BOTH = 3'd4
  } trig_e;

  localparam int CFG_EN_BIT = 7;

  // Decide whether a trigger code fires for a given current/previous sample.
  function automatic logic trig_fire(input logic [2:0] code, input logic cur, input logic prev);
    logic fire;
    case (code)
      TRG_LOW:  fire = ~cur;
      TRG_HIGH: fire = cur;
      TRG_FALL: fire = prev & ~cur;
      TRG_RISE: fire = cur & ~prev;
      TRG_BOTH: fire = cur ^ prev;
      default:  fire = 1'b0;
    endcase
    return fire;
  endfunction

  // Status byte that holds source n, and bit inside that byte.
  function automatic int stat_byte_of(input int n);
    return n / 8;
  endfunction

  function automatic int stat_bit_of(input int n);
    return n % 8;
  endfunction

endpackage

// File: rtl/pin_event_sync.sv
module pin_event_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] cur_o,
  output logic [WIDTH-1:0] prev_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] cur_q;
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;

endmodule

// File: rtl/pin_event_detect.sv
module pin_event_detect
  import pin_event_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic [NUM_SRC-1:0][2:0] code_i,
  input  logic [NUM_SRC-1:0]      cur_i,
  input  logic [NUM_SRC-1:0]      prev_i,
  output logic [NUM_SRC-1:0]      hit_o
);

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    assign hit_o[n] = trig_fire(code_i[n], cur_i[n], prev_i[n]);
  end

endmodule

// File: rtl/pin_event_regs.sv
module pin_event_regs
  import pin_event_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int ADDR_W    = 12,
  parameter int CFG_BASE  = 'h300,
  parameter int STAT_BASE = 'h360
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    we_i,
  input  logic [7:0]              wdata_i,
  output logic [7:0]              rdata_o,
  input  logic [NUM_SRC-1:0]      hit_i,
  output logic [NUM_SRC-1:0][2:0] code_o,
  output logic [NUM_SRC-1:0]      en_o,
  output logic [NUM_SRC-1:0]      status_o,
  output logic [NUM_SRC-1:0]      clr_o
);

  localparam int STAT_BYTES = (NUM_SRC + 7) / 8;

  logic [NUM_SRC-1:0][7:0] cfg_q;
  logic [NUM_SRC-1:0]      cfg_wr;
  logic [NUM_SRC-1:0]      status_q;
  logic [NUM_SRC-1:0]      clr_vec;
  logic [7:0]              rd_mux;
  logic [7:0]              rdata_q;

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_cfg
    assign cfg_wr[n]  = we_i && (addr_i == ADDR_W'(CFG_BASE + n));
    assign clr_vec[n] = we_i && (addr_i == ADDR_W'(STAT_BASE + stat_byte_of(n)))
                        && wdata_i[stat_bit_of(n)];
    assign code_o[n]  = cfg_q[n][2:0];
    assign en_o[n]    = cfg_q[n][CFG_EN_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cfg_q[n] <= '0;
      else if (cfg_wr[n]) cfg_q[n] <= wdata_i;
    end
  end

  // Detection has priority over a simultaneous clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_vec) | hit_i;
  end

  always_comb begin
    rd_mux = '0;
    for (int n = 0; n < NUM_SRC; n++) begin
      if (addr_i == ADDR_W'(CFG_BASE + n)) rd_mux = cfg_q[n];
    end
    for (int k = 0; k < STAT_BYTES; k++) begin
      if (addr_i == ADDR_W'(STAT_BASE + k)) begin
        for (int b = 0; b < 8; b++) begin
          if (k * 8 + b < NUM_SRC) rd_mux[b] = status_q[k * 8 + b];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rd_mux;
  end

  assign rdata_o  = rdata_q;
  assign status_o = status_q;
  assign clr_o    = clr_vec;

endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq #(
  parameter int NUM_SRC   = 32,
  parameter int ADDR_W    = 12,
  parameter int CFG_BASE  = 'h300,
  parameter int STAT_BASE = 'h360
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pins_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic               bus_we_i,
  input  logic [7:0]         bus_wdata_i,
  output logic [7:0]         bus_rdata_o,
  output logic               irq_o
);

  // Named internal events, visible to the bound checker.
  logic [NUM_SRC-1:0]      sync_cur;
  logic [NUM_SRC-1:0]      sync_prev;
  logic [NUM_SRC-1:0][2:0] code_vec;
  logic [NUM_SRC-1:0]      en_vec;
  logic [NUM_SRC-1:0]      hit_vec;
  logic [NUM_SRC-1:0]      status_q;
  logic [NUM_SRC-1:0]      clr_vec;
  logic [NUM_SRC-1:0]      live_vec;

  pin_event_sync #(.WIDTH(NUM_SRC)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (pins_i),
    .cur_o  (sync_cur),
    .prev_o (sync_prev)
  );

  pin_event_detect #(.NUM_SRC(NUM_SRC)) u_detect (
    .code_i (code_vec),
    .cur_i  (sync_cur),
    .prev_i (sync_prev),
    .hit_o  (hit_vec)
  );

  pin_event_regs #(
    .NUM_SRC   (NUM_SRC),
    .ADDR_W    (ADDR_W),
    .CFG_BASE  (CFG_BASE),
    .STAT_BASE (STAT_BASE)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_i   (bus_addr_i),
    .we_i     (bus_we_i),
    .wdata_i  (bus_wdata_i),
    .rdata_o  (bus_rdata_o),
    .hit_i    (hit_vec),
    .code_o   (code_vec),
    .en_o     (en_vec),
    .status_o (status_q),
    .clr_o    (clr_vec)
  );

  assign live_vec = status_q & en_vec;
  assign irq_o    = |live_vec;

endmodule

// File: rtl/pin_event_irq_chk.sv
module pin_event_irq_chk #(
  parameter int NUM_SRC = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] en_vec,
  input logic [NUM_SRC-1:0] hit_vec,
  input logic [NUM_SRC-1:0] clr_vec
);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((($past(status_q) & ~$past(clr_vec)) & ~status_q)) == '0));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(clr_vec & ~hit_vec)) == '0));

  assert_hit_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(hit_vec)) == $past(hit_vec)));

  assert_set_only_by_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(hit_vec)) == '0));

  assert_irq_needs_enable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (en_vec == '0) |-> !irq_o);

  assert_reset_disabled_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (en_vec == '0));

endmodule

bind pin_event_irq pin_event_irq_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_o    (irq_o),
  .status_q (status_q),
  .en_vec   (en_vec),
  .hit_vec  (hit_vec),
  .clr_vec  (clr_vec)
);

// File: tb/pin_event_irq_bench.sv
module pin_event_irq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 12;
  localparam int AW         = 12;
  localparam int CB         = 'h300;
  localparam int SB         = 'h360;
  localparam int WDOG_CYC   = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pins = '0;
  logic [AW-1:0] addr = '0;
  logic          we = 1'b0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  pin_event_irq #(.NUM_SRC(N), .ADDR_W(AW), .CFG_BASE(CB), .STAT_BASE(SB)) u_pin_event_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .pins_i      (pins),
    .bus_addr_i  (addr),
    .bus_we_i    (we),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input int a, input int d);
    @(negedge clk);
    addr = AW'(a); wdata = 8'(d); we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_rd(input int a, output logic [7:0] d);
    @(negedge clk);
    addr = AW'(a); we = 1'b0;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic idle(input int cyc);
    for (int i = 0; i < cyc; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < WDOG_CYC; c++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x%0h expected=0x%0h", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] v0;
    logic [7:0] v1;
    int exp_bit;

    // R13: reset state.
    idle(3);
    check(rdata == 8'h00, "R13 rdata in reset", rdata, 0);
    check(irq == 1'b0, "R13 irq in reset", irq, 0);
    rst_n = 1'b1;
    idle(4);
    for (int s = 0; s < N; s++) begin
      bus_rd(CB + s, d);
      check(d == 8'h00, "R13 cfg after reset", d, 0);
    end
    check(irq == 1'b0, "R13 irq after reset", irq, 0);
    // R3/R8/R11: default low-level trigger, pins low, disabled.
    bus_rd(SB, d);
    check(d == 8'hFF, "R3 R8 byte0 low level", d, 'hFF);
    bus_rd(SB + 1, d);
    check(d == 8'h0F, "R8 byte1 unused bits zero", d, 'h0F);

    // R2: read latency.
    bus_wr(CB + 0, 'h15);
    bus_wr(CB + 1, 'h2A);
    bus_rd(CB + 0, v0);
    @(negedge clk);
    addr = AW'(CB + 1);
    #1;
    check(rdata == v0, "R2 data held before edge", rdata, v0);
    @(negedge clk);
    v1 = rdata;
    check(v1 == 8'h2A, "R2 data after one edge", v1, 'h2A);

    // R9/R11/R12: write-one-to-clear with mixed bits, disabled sources.
    for (int s = 0; s < N; s++) bus_wr(CB + s, 'h03);
    bus_wr(SB, 'hFF);
    bus_wr(SB + 1, 'hFF);
    bus_rd(SB, d);
    check(d == 8'h00, "R9 clear all byte0", d, 0);
    pins = '1;
    idle(4);
    pins = '0;
    idle(4);
    bus_rd(SB, d);
    check(d == 8'hFF, "R11 set while disabled", d, 'hFF);
    check(irq == 1'b0, "R12 no irq when disabled", irq, 0);
    bus_wr(SB, 'hA5);
    bus_rd(SB, d);
    check(d == 8'h5A, "R9 mixed clear", d, 'h5A);
    bus_wr(SB + 1, 'h00);
    bus_rd(SB + 1, d);
    check(d == 8'h0F, "R9 zero write keeps", d, 'h0F);
    bus_wr(CB + 1, 'h83);
    check(irq == 1'b1, "R12 enable pending raises irq", irq, 1);
    bus_wr(CB + 0, 'h83);
    check(irq == 1'b1, "R12 irq stays with one live", irq, 1);
    bus_wr(SB, 'h02);
    check(irq == 1'b0, "R12 irq drops after clear", irq, 0);
    for (int s = 0; s < N; s++) bus_wr(CB + s, 'h00);

    // R1, R3-R8, R10, R12: every source through every trigger code.
    for (int s = 0; s < N; s++) begin
      for (int m = 0; m < 8; m++) begin
        int cfgv;
        cfgv = 'h80 | ((s % 16) << 3) | m;
        bus_wr(CB + s, cfgv);
        bus_rd(CB + s, d);
        check(d == 8'(cfgv), "R1 cfg readback", d, cfgv);
        idle(4);
        // pin low, clear: only low level (R3, R10) refires.
        bus_wr(SB + s / 8, 1 << (s % 8));
        bus_rd(SB + s / 8, d);
        exp_bit = (8'h01 >> m) & 1;
        check(d[s % 8] == exp_bit[0], "R3 R10 low steady", d[s % 8], exp_bit);
        check(irq == exp_bit[0], "R12 irq low steady", irq, exp_bit);
        // rising pin: R4 R5 R6 R7
        pins[s] = 1'b1;
        idle(4);
        bus_rd(SB + s / 8, d);
        exp_bit = (8'h1B >> m) & 1;
        check(d[s % 8] == exp_bit[0], "R5 R6 R7 after rise", d[s % 8], exp_bit);
        check(irq == exp_bit[0], "R12 irq after rise", irq, exp_bit);
        // clear with pin high: only high level (R4) refires.
        bus_wr(SB + s / 8, 1 << (s % 8));
        bus_rd(SB + s / 8, d);
        exp_bit = (8'h02 >> m) & 1;
        check(d[s % 8] == exp_bit[0], "R4 R10 high steady", d[s % 8], exp_bit);
        // falling pin.
        pins[s] = 1'b0;
        idle(4);
        bus_rd(SB + s / 8, d);
        exp_bit = (8'h17 >> m) & 1;
        check(d[s % 8] == exp_bit[0], "R5 R6 R7 after fall", d[s % 8], exp_bit);
        check(irq == exp_bit[0], "R12 irq after fall", irq, exp_bit);
      end
      bus_wr(CB + s, 'h00);
      check(irq == 1'b0, "R12 irq off when disabled", irq, 0);
    end

    done = 1'b1;
    finish_run();
  end

endmodule